// File: doc/BRIEF.md
# Two-Stage SPI Bit Clock Generator

This block derives the serial bit clock of an SPI master from the system clock. It uses two dividers in cascade. The first stage is an even-only prescaler set by an 8-bit value. The second stage counts prescaler outputs and divides again by one plus an 8-bit rate value. The bit period is therefore the prescale value times (1 + rate value) system clocks. The shortest period is two clocks, with prescale 2 and rate 0. The longest is 254 × 256 clocks.

The block emits a one-cycle tick at each half bit period, which is twice the bit rate. The data shifter uses this tick as its clock enable. The block also drives the serial clock level, which toggles on every tick. While the run control is low, both counters are held cleared, no ticks are issued, and the serial clock rests at the programmed idle polarity. The divider settings are captured only when a half period starts. A change made in the middle of a count therefore applies from the next half period.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, tick_o is 0 and sclk_o is 0.
- R2: While run_i is low, tick_o stays 0, and sclk_o equals the cpol_i value sampled on the previous clock edge.
- R3: With run_i held high and the settings steady, successive tick_o pulses are exactly H cycles apart. H = (P/2)·(R+1), where P is the effective prescale value and R is rate_i.
- R4: While running, sclk_o inverts in exactly those cycles in which tick_o is high, and holds its level in all other cycles.
- R5: After run_i rises, the first tick_o comes after the H-th clock edge at which run_i is sampled high, which is one full half period.
- R6: Bit 0 of presc_i is ignored, so odd values give the same period as the even value one below.
- R7: A presc_i value of 0 or 1 behaves as a prescale of 2.
- R8: The extremes are met. P=2 with R=0 gives a tick every cycle (bit rate = clock/2). P=254 with R=255 gives H = 32512.
- R9: Settings changed during a half period do not alter that half period. They take effect from the half period that starts at the next tick.
- R10: When run_i falls, ticks stop and sclk_o returns to cpol_i on the next edge. A later restart waits a full half period again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | High to generate the clock, low to idle |
| cpol_i | input | 1 | Idle level of the serial clock |
| presc_i | input | PRE_W | Prescale value (even, LSB ignored, minimum 2) |
| rate_i | input | RATE_W | Rate value; second-stage divide is 1 + rate_i |
| tick_o | output | 1 | One-cycle pulse at each half bit period |
| sclk_o | output | 1 | Serial clock level |

## Verification
The checker holds a cycle-accurate expectation of each tick. It captures the settings on the inputs whenever the block idles and at every predicted tick. This assumes that presc_i and rate_i are stable at the edge where a half period begins, and that run_i changes only at clock edges. The bench meets this by driving every input one time unit after a rising edge. It programs the settings at least two cycles before raising run_i, and makes mid-run changes only at points where the new values must wait for the next reload. The idle-level and toggle checks assume that cpol_i changes only while idle, and the stimulus changes it only there.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  localparam int unsigned PRE_W_DEF  = 8;
  localparam int unsigned RATE_W_DEF = 8;
  localparam int unsigned ARG_W      = 16;

  // Prescale value to first-stage count length: the LSB is dropped (even-only
  // divide) and a result of zero is raised to one (minimum prescale of two).
  function automatic logic [ARG_W-1:0] half_count(input logic [ARG_W-1:0] presc);
    logic [ARG_W-1:0] h;
    h = presc >> 1;
    if (h == '0) h = ARG_W'(1);
    return h;
  endfunction

endpackage

// File: rtl/spi_sclk_prestage.sv
// First stage: counts prescaler cycles and pulses hit_o at the end of each.
module spi_sclk_prestage #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (hit_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_sclk_ratestage.sv
// Second stage: counts first-stage hits, fires once per (lim_i + 1) hits.
module spi_sclk_ratestage #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = step_i && (cnt_q == lim_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (tick_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_sclk_level.sv
// Output register stage: registered tick and serial clock level.
module spi_sclk_level (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic cpol_i,
  input  logic tick_i,
  output logic tick_o,
  output logic sclk_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o <= 1'b0;
      sclk_o <= 1'b0;
    end else begin
      tick_o <= tick_i;
      if (!run_i)      sclk_o <= cpol_i;
      else if (tick_i) sclk_o <= ~sclk_o;
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int unsigned PRE_W  = spi_sclk_pkg::PRE_W_DEF,
  parameter int unsigned RATE_W = spi_sclk_pkg::RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic [PRE_W-1:0]  presc_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o,
  output logic              sclk_o
);
  import spi_sclk_pkg::*;

  localparam int unsigned HALF_W = (PRE_W > 1) ? PRE_W - 1 : 1;

  logic [ARG_W-1:0]  half_w;
  logic [HALF_W-1:0] pre_lim_d;
  logic [HALF_W-1:0] pre_lim_q;
  logic [RATE_W-1:0] rate_lim_q;
  logic              pre_hit;
  logic              tick_c;
  logic              reload;

  // Normalised first-stage limit (count length minus one)
  assign half_w    = half_count(ARG_W'(presc_i));
  assign pre_lim_d = HALF_W'(half_w - ARG_W'(1));

  // Settings are captured only at a half-period boundary or while idle
  assign reload = !run_i || tick_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_lim_q  <= '0;
      rate_lim_q <= '0;
    end else if (reload) begin
      pre_lim_q  <= pre_lim_d;
      rate_lim_q <= rate_i;
    end
  end

  spi_sclk_prestage #(.CNT_W(HALF_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .run_i (run_i),
    .lim_i (pre_lim_q),
    .hit_o (pre_hit)
  );

  spi_sclk_ratestage #(.CNT_W(RATE_W)) u_rate (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_i),
    .step_i (pre_hit),
    .lim_i  (rate_lim_q),
    .tick_o (tick_c)
  );

  spi_sclk_level u_lvl (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run_i),
    .cpol_i (cpol_i),
    .tick_i (tick_c),
    .tick_o (tick_o),
    .sclk_o (sclk_o)
  );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned RATE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              run_i,
  input logic              cpol_i,
  input logic [PRE_W-1:0]  presc_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              tick_o,
  input logic              sclk_o
);
  import spi_sclk_pkg::*;

  logic        past_ok;
  logic [31:0] cyc_q;
  logic [31:0] span_q;
  logic        exp_q;
  logic [31:0] span_d;
  logic        due;

  // Expected half period from the inputs as they stand
  assign span_d = 32'(half_count(ARG_W'(presc_i))) * (32'(rate_i) + 32'd1);
  assign due    = run_i && ((cyc_q + 32'd1) == span_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      cyc_q   <= '0;
      span_q  <= 32'd1;
      exp_q   <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      exp_q   <= due;
      if (!run_i || due) begin
        cyc_q  <= '0;
        span_q <= span_d;
      end else begin
        cyc_q <= cyc_q + 32'd1;
      end
    end
  end

  // R3 R5 R9
  tick_exact_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (tick_o == exp_q));

  // R2 R10
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(run_i)) |-> (sclk_o == $past(cpol_i)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(run_i)) |-> !tick_o);

  // R4
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(run_i)) |-> ((sclk_o != $past(sclk_o)) == tick_o));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run_i   (run_i),
  .cpol_i  (cpol_i),
  .presc_i (presc_i),
  .rate_i  (rate_i),
  .tick_o  (tick_o),
  .sclk_o  (sclk_o)
);

// File: tb/spi_sclk_gen_tb.sv
`timescale 1ns/1ps
module spi_sclk_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_i = 1'b0;
  logic       cpol_i = 1'b0;
  logic [7:0] presc_i = 8'd2;
  logic [7:0] rate_i = 8'd0;
  logic       tick_o;
  logic       sclk_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_sclk_gen u_dut (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run_i),
    .cpol_i  (cpol_i),
    .presc_i (presc_i),
    .rate_i  (rate_i),
    .tick_o  (tick_o),
    .sclk_o  (sclk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Program settings while idle, then raise run just after an edge.
  task automatic start(input int p, input int r, input bit cp);
    run_i   = 1'b0;
    presc_i = 8'(p);
    rate_i  = 8'(r);
    cpol_i  = cp;
    step();
    step();
    run_i = 1'b1;
  endtask

  // Edges until tick_o is seen; also reports whether sclk toggled on it.
  task automatic wait_tick(input int limit, output int n, output bit toggled);
    logic prev;
    n = 0;
    toggled = 1'b0;
    do begin
      prev = sclk_o;
      step();
      n++;
      if (tick_o) toggled = (sclk_o != prev);
    end while (!tick_o && n < limit);
  endtask

  task automatic stop();
    run_i = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cpol_i = 1'b1;
    step();
    step();
    chk(tick_o == 1'b0, "R1 tick in reset", int'(tick_o), 0);
    chk(sclk_o == 1'b0, "R1 sclk in reset", int'(sclk_o), 0);
    rst = 1'b0;
    step();
    chk(tick_o == 1'b0, "R1 tick after reset", int'(tick_o), 0);
  endtask

  task automatic t_idle();
    int ticks = 0;
    run_i = 1'b0;
    cpol_i = 1'b1;
    step();
    chk(sclk_o == 1'b1, "R2 idle level high", int'(sclk_o), 1);
    cpol_i = 1'b0;
    step();
    chk(sclk_o == 1'b0, "R2 idle level low", int'(sclk_o), 0);
    for (int i = 0; i < 6; i++) begin
      step();
      if (tick_o) ticks++;
    end
    chk(ticks == 0, "R2 no ticks idle", ticks, 0);
  endtask

  // Measure first tick and two following spacings
  task automatic t_rate(input int p, input int r, input bit cp, input int h, input string req);
    int n;
    bit tg;
    start(p, r, cp);
    wait_tick(h + 10, n, tg);
    chk(n == h, {req, " R5 first tick"}, n, h);
    chk(sclk_o == !cp, {req, " R4 first edge level"}, int'(sclk_o), int'(!cp));
    for (int k = 0; k < 2; k++) begin
      wait_tick(h + 10, n, tg);
      chk(n == h, {req, " R3 spacing"}, n, h);
      chk(tg, {req, " R4 toggle on tick"}, int'(tg), 1);
    end
    stop();
  endtask

  task automatic t_slowest();
    int n;
    bit tg;
    start(254, 255, 1'b0);
    wait_tick(33000, n, tg);
    chk(n == 32512, "R8 slowest half period", n, 32512);
    chk(tg, "R8 slowest toggle", int'(tg), 1);
    stop();
  endtask

  task automatic t_midchange();
    int n;
    bit tg;
    start(4, 1, 1'b0);               // H = 4
    step();
    step();
    presc_i = 8'd2;                  // H = 1 from next reload
    rate_i  = 8'd0;
    wait_tick(20, n, tg);
    chk(n == 2, "R9 current half unchanged", n + 2, 4);
    wait_tick(20, n, tg);
    chk(n == 1, "R9 new setting applied", n, 1);
    stop();
  endtask

  task automatic t_rundrop();
    int n;
    bit tg;
    int ticks = 0;
    start(6, 0, 1'b1);               // H = 3
    wait_tick(20, n, tg);
    chk(sclk_o == 1'b0, "R10 toggled low", int'(sclk_o), 0);
    run_i = 1'b0;
    step();
    chk(sclk_o == 1'b1, "R10 back to idle level", int'(sclk_o), 1);
    for (int i = 0; i < 5; i++) begin
      step();
      if (tick_o) ticks++;
    end
    chk(ticks == 0, "R10 no ticks after stop", ticks, 0);
    run_i = 1'b1;
    wait_tick(20, n, tg);
    chk(n == 3, "R10 restart full half", n, 3);
    stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_rate(8, 2, 1'b0, 12, "R3");
    t_rate(10, 4, 1'b1, 25, "R3b");
    t_rate(5, 2, 1'b0, 6, "R6 odd");
    t_rate(4, 2, 1'b0, 6, "R6 even");
    t_rate(0, 3, 1'b1, 4, "R7 zero");
    t_rate(1, 0, 1'b0, 1, "R7 one");
    t_rate(2, 0, 1'b1, 1, "R8 fastest");
    t_slowest();
    t_midchange();
    t_rundrop();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule